// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a 48-bit virtual address into a physical address by reading page table entries from memory, one level at a time, starting from a supplied root table base and starting level. Each step reads one 64-bit entry over a request/response memory port. The walker follows pointer entries down the tree, checks the leaf entry against the access type, privilege and the two permission modifier flags, and reports either a translated address or a fault code.

A client pulses `start_i` with the address and access attributes. The walker raises `busy_o`, issues one memory read per level and, when it finishes, raises `done_o`. It keeps the outcome on its outputs until the next accepted start. Large leaves found above the lowest level (superpages) are checked for alignment, and the untranslated low virtual page bits are merged into the result. A global indication is gathered from every entry visited on the way down.

Top module: `ptw48_walker`

## Requirements
- R1: The entry address at level L is the current table base plus 8 times the 9-bit index taken from virtual address bits [12+9L+8 : 12+9L]. The first read of a walk uses the root base and the starting level.
- R2: Each read is a single request held with a stable address until `mem_req_ready_i` is high. At most one read is outstanding, and a walk of N levels makes exactly N reads.
- R3: A response with `mem_rsp_err_i` high ends the walk with fault code 1 (access).
- R4: An entry with bit 0 (valid) clear, or with bit 2 (write) set and bit 1 (read) clear, ends the walk with fault code 2 (invalid).
- R5: A pointer entry (valid set; read, write and execute bits 1, 2 and 3 all clear) found at level 0 gives fault code 2. Above level 0 it starts the next read one level down, using entry bits [53:10] shifted left by 12 as the new table base.
- R6: `global_o` is the OR of `global_i` and bit 5 of every entry read in the walk, the leaf included.
- R7: Leaf permission check. Access codes are 0 = load, 1 = store, 2 = fetch. With `user_i` high the entry's user bit (bit 4) must be set. With `user_i` low a user-bit entry is allowed only when `sum_i` is high and the access is not a fetch. A load needs the read bit, or the execute bit when `mxr_i` is high. A store needs the write bit and a fetch needs the execute bit. Failure gives fault code 3.
- R8: A permitted leaf at level L>0 whose PPN has any of its low 9L bits set gives fault code 4 (misaligned).
- R9: A good leaf at level L>0 yields PA = {PPN OR (VPN AND ((1<<9L)-1)), VA[11:0]}.
- R10: A good leaf at level 0 yields PA = {PPN, VA[11:0]}, with fault code 0. `level_o`, `pte_o` and `pte_addr_o` give the leaf's level, the leaf word and the leaf's address.
- R11: `start_i` is accepted only while `busy_o` is low, and a start during a walk has no effect. `done_o` and the results stay unchanged until the next accepted start.
- R12: After reset `busy_o`, `done_o` and `mem_req_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (used when idle) |
| va_i | input | 48 | Virtual address |
| acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| user_i | input | 1 | Requester runs at user privilege |
| mxr_i | input | 1 | Loads may read execute-only pages |
| sum_i | input | 1 | Supervisor may touch user pages |
| root_i | input | 56 | Root table physical base |
| start_level_i | input | 2 | Level of the first read |
| global_i | input | 1 | Incoming global indication |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Result valid, held until next start |
| fault_o | output | 3 | 0 ok, 1 access, 2 invalid, 3 permission, 4 misaligned |
| pa_o | output | 56 | Translated physical address |
| pte_o | output | 64 | Leaf entry word |
| pte_addr_o | output | 56 | Address of the leaf entry |
| level_o | output | 2 | Level of the leaf |
| global_o | output | 1 | Accumulated global indication |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_addr_o | output | 56 | Read request address |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | Read data returned |
| mem_rsp_data_i | input | 64 | Read data word |
| mem_rsp_err_i | input | 1 | Read failed |

## Verification
The bench builds page trees in a memory model and aims at the boundaries. It checks a pointer at the bottom level, which a careless walker would follow into garbage instead of faulting. It checks write-without-read encodings, which would leak through as valid leaves if only bit 0 were decoded. It uses superpages with exactly one stray PPN bit inside the mask, which a wrong mask width would accept or reject wrongly. It covers each supervisor/user/MXR combination, where a swapped condition shows up as a wrong fault code. It also checks a G bit present only on the top pointer, which a non-sticky flag would drop, and start levels below the top, where a wrong index slice or read count changes the reported entry address. A start pulse during a walk checks that the walk in progress is not restarted.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   // entry flag bit positions (decoded by the walker and the bench)
   localparam int unsigned PTE_BIT_V = 0;
   localparam int unsigned PTE_BIT_R = 1;
   localparam int unsigned PTE_BIT_W = 2;
   localparam int unsigned PTE_BIT_X = 3;
   localparam int unsigned PTE_BIT_U = 4;
   localparam int unsigned PTE_BIT_G = 5;

   localparam logic [1:0] ACC_LOAD  = 2'd0;
   localparam logic [1:0] ACC_STORE = 2'd1;
   localparam logic [1:0] ACC_FETCH = 2'd2;

   typedef enum logic [2:0] {
      FLT_NONE     = 3'd0,
      FLT_ACCESS   = 3'd1,
      FLT_INVALID  = 3'd2,
      FLT_PERM     = 3'd3,
      FLT_MISALIGN = 3'd4
   } walk_fault_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } walk_state_t;

   typedef struct packed {
      logic bad;
      logic ptr;
      logic r;
      logic w;
      logic x;
      logic u;
      logic g;
   } entry_kind_t;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int unsigned LEVELS  = 4,
   parameter int unsigned LVL_W   = 9,
   parameter int unsigned PA_W    = 56,
   parameter int unsigned PTE_LOG = 3,
   localparam int unsigned VPN_W   = LEVELS * LVL_W,
   localparam int unsigned LIDX_W  = $clog2(LEVELS)
) (
   input  logic [PA_W-1:0]   base_i,
   input  logic [VPN_W-1:0]  vpn_i,
   input  logic [LIDX_W-1:0] level_i,
   output logic [PA_W-1:0]   addr_o
);

   logic [LVL_W-1:0] idx_tbl [LEVELS];
   logic [LVL_W-1:0] idx;

   for (genvar g = 0; g < LEVELS; g++) begin : g_idx
      assign idx_tbl[g] = vpn_i[g*LVL_W +: LVL_W];
   end

   assign idx    = idx_tbl[level_i];
   assign addr_o = base_i + (PA_W'(idx) << PTE_LOG);

endmodule

// File: rtl/ptw_pte_classify.sv
module ptw_pte_classify
   import ptw_pkg::*;
#(
   parameter int unsigned PTE_W       = 64,
   parameter int unsigned PPN_W       = 44,
   parameter int unsigned PTE_PPN_LSB = 10
) (
   input  logic [PTE_W-1:0] pte_i,
   output entry_kind_t      kind_o,
   output logic [PPN_W-1:0] ppn_o
);

   logic v;
   logic unused_bits;

   assign v = pte_i[PTE_BIT_V];

   always_comb begin
      kind_o.r   = pte_i[PTE_BIT_R];
      kind_o.w   = pte_i[PTE_BIT_W];
      kind_o.x   = pte_i[PTE_BIT_X];
      kind_o.u   = pte_i[PTE_BIT_U];
      kind_o.g   = pte_i[PTE_BIT_G];
      kind_o.bad = !v || (pte_i[PTE_BIT_W] && !pte_i[PTE_BIT_R]);
      kind_o.ptr = v && !pte_i[PTE_BIT_R] && !pte_i[PTE_BIT_W] && !pte_i[PTE_BIT_X];
   end

   assign ppn_o       = pte_i[PTE_PPN_LSB +: PPN_W];
   assign unused_bits = ^{pte_i[PTE_W-1:PTE_PPN_LSB+PPN_W], pte_i[PTE_PPN_LSB-1:PTE_BIT_G+1]};

endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
   import ptw_pkg::*;
(
   input  entry_kind_t kind_i,
   input  logic [1:0]  acc_i,
   input  logic        user_i,
   input  logic        mxr_i,
   input  logic        sum_i,
   output logic        ok_o
);

   logic priv_ok;
   logic type_ok;

   always_comb begin
      if (user_i) priv_ok = kind_i.u;
      else        priv_ok = !kind_i.u || (sum_i && (acc_i != ACC_FETCH));

      unique case (acc_i)
         ACC_LOAD:  type_ok = kind_i.r || (mxr_i && kind_i.x);
         ACC_STORE: type_ok = kind_i.w;
         ACC_FETCH: type_ok = kind_i.x;
         default:   type_ok = 1'b0;
      endcase
   end

   assign ok_o = priv_ok && type_ok;

endmodule

// File: rtl/ptw_leaf_compose.sv
module ptw_leaf_compose #(
   parameter int unsigned LEVELS = 4,
   parameter int unsigned LVL_W  = 9,
   parameter int unsigned PPN_W  = 44,
   localparam int unsigned VPN_W  = LEVELS * LVL_W,
   localparam int unsigned LIDX_W = $clog2(LEVELS)
) (
   input  logic [PPN_W-1:0]  ppn_i,
   input  logic [VPN_W-1:0]  vpn_i,
   input  logic [LIDX_W-1:0] level_i,
   output logic              misaligned_o,
   output logic [PPN_W-1:0]  ppn_o
);

   logic [PPN_W-1:0] mask_tbl [LEVELS];
   logic [PPN_W-1:0] mask;

   for (genvar g = 0; g < LEVELS; g++) begin : g_mask
      assign mask_tbl[g] = (PPN_W'(1) << (g * LVL_W)) - PPN_W'(1);
   end

   assign mask         = mask_tbl[level_i];
   assign misaligned_o = |(ppn_i & mask);
   assign ppn_o        = ppn_i | (PPN_W'(vpn_i) & mask);

endmodule

// File: rtl/ptw48_walker.sv
module ptw48_walker
   import ptw_pkg::*;
#(
   parameter int unsigned LEVELS      = 4,
   parameter int unsigned LVL_W       = 9,
   parameter int unsigned PGOFS_W     = 12,
   parameter int unsigned PPN_W       = 44,
   parameter int unsigned PTE_W       = 64,
   parameter int unsigned PTE_PPN_LSB = 10,
   parameter int unsigned PTE_LOG     = 3,
   localparam int unsigned VPN_W      = LEVELS * LVL_W,
   localparam int unsigned VA_W       = VPN_W + PGOFS_W,
   localparam int unsigned PA_W       = PPN_W + PGOFS_W,
   localparam int unsigned LIDX_W     = $clog2(LEVELS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [VA_W-1:0]   va_i,
   input  logic [1:0]        acc_i,
   input  logic              user_i,
   input  logic              mxr_i,
   input  logic              sum_i,
   input  logic [PA_W-1:0]   root_i,
   input  logic [LIDX_W-1:0] start_level_i,
   input  logic              global_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [2:0]        fault_o,
   output logic [PA_W-1:0]   pa_o,
   output logic [PTE_W-1:0]  pte_o,
   output logic [PA_W-1:0]   pte_addr_o,
   output logic [LIDX_W-1:0] level_o,
   output logic              global_o,
   output logic              mem_req_valid_o,
   output logic [PA_W-1:0]   mem_req_addr_o,
   input  logic              mem_req_ready_i,
   input  logic              mem_rsp_valid_i,
   input  logic [PTE_W-1:0]  mem_rsp_data_i,
   input  logic              mem_rsp_err_i
);

   initial begin
      assert (LEVELS >= 2) else $error("walker needs at least two levels");
      assert (VPN_W <= PPN_W) else $error("VPN wider than PPN");
      assert (PTE_PPN_LSB + PPN_W <= PTE_W) else $error("PPN field exceeds entry");
      assert ((8 << PTE_LOG) == PTE_W) else $error("entry size and log size disagree");
      assert (PTE_PPN_LSB > PTE_BIT_G + 1) else $error("PPN overlaps flag bits");
   end

   // walk context
   walk_state_t       st_q;
   logic [VA_W-1:0]   va_q;
   logic [1:0]        acc_q;
   logic              user_q, mxr_q, sum_q;
   logic [PA_W-1:0]   base_q;
   logic [LIDX_W-1:0] lvl_q;
   logic              glob_q;

   // held results
   logic              done_q;
   walk_fault_t       fault_q;
   logic [PA_W-1:0]   pa_q;
   logic [PTE_W-1:0]  pte_q;
   logic [PA_W-1:0]   pteaddr_q;
   logic [LIDX_W-1:0] lvlout_q;
   logic              globout_q;

   logic [PA_W-1:0]   entry_addr;
   entry_kind_t       kind;
   logic [PPN_W-1:0]  ent_ppn;
   logic              perm_ok;
   logic              misal;
   logic [PPN_W-1:0]  out_ppn;
   logic              glob_n;
   logic              fin, descend;
   walk_fault_t       fin_code;

   ptw_addr_gen #(
      .LEVELS(LEVELS), .LVL_W(LVL_W), .PA_W(PA_W), .PTE_LOG(PTE_LOG)
   ) u_addr_gen (
      .base_i  (base_q),
      .vpn_i   (va_q[VA_W-1:PGOFS_W]),
      .level_i (lvl_q),
      .addr_o  (entry_addr)
   );

   ptw_pte_classify #(
      .PTE_W(PTE_W), .PPN_W(PPN_W), .PTE_PPN_LSB(PTE_PPN_LSB)
   ) u_classify (
      .pte_i  (mem_rsp_data_i),
      .kind_o (kind),
      .ppn_o  (ent_ppn)
   );

   ptw_perm_check u_perm (
      .kind_i (kind),
      .acc_i  (acc_q),
      .user_i (user_q),
      .mxr_i  (mxr_q),
      .sum_i  (sum_q),
      .ok_o   (perm_ok)
   );

   ptw_leaf_compose #(
      .LEVELS(LEVELS), .LVL_W(LVL_W), .PPN_W(PPN_W)
   ) u_leaf (
      .ppn_i        (ent_ppn),
      .vpn_i        (va_q[VA_W-1:PGOFS_W]),
      .level_i      (lvl_q),
      .misaligned_o (misal),
      .ppn_o        (out_ppn)
   );

   assign glob_n = glob_q | kind.g;

   // classify the returned word
   always_comb begin
      fin      = 1'b0;
      descend  = 1'b0;
      fin_code = FLT_NONE;
      if (st_q == ST_WAIT && mem_rsp_valid_i) begin
         if (mem_rsp_err_i) begin
            fin      = 1'b1;
            fin_code = FLT_ACCESS;
         end else if (kind.bad) begin
            fin      = 1'b1;
            fin_code = FLT_INVALID;
         end else if (kind.ptr) begin
            if (lvl_q == '0) begin
               fin      = 1'b1;
               fin_code = FLT_INVALID;
            end else begin
               descend = 1'b1;
            end
         end else begin
            fin = 1'b1;
            if (!perm_ok)   fin_code = FLT_PERM;
            else if (misal) fin_code = FLT_MISALIGN;
            else            fin_code = FLT_NONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         va_q      <= '0;
         acc_q     <= ACC_LOAD;
         user_q    <= 1'b0;
         mxr_q     <= 1'b0;
         sum_q     <= 1'b0;
         base_q    <= '0;
         lvl_q     <= '0;
         glob_q    <= 1'b0;
         done_q    <= 1'b0;
         fault_q   <= FLT_NONE;
         pa_q      <= '0;
         pte_q     <= '0;
         pteaddr_q <= '0;
         lvlout_q  <= '0;
         globout_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  st_q   <= ST_REQ;
                  va_q   <= va_i;
                  acc_q  <= acc_i;
                  user_q <= user_i;
                  mxr_q  <= mxr_i;
                  sum_q  <= sum_i;
                  base_q <= root_i;
                  lvl_q  <= start_level_i;
                  glob_q <= global_i;
                  done_q <= 1'b0;
               end
            end
            ST_REQ: begin
               if (mem_req_ready_i) st_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (descend) begin
                  st_q   <= ST_REQ;
                  base_q <= {ent_ppn, {PGOFS_W{1'b0}}};
                  lvl_q  <= lvl_q - 1'b1;
                  glob_q <= glob_n;
               end else if (fin) begin
                  st_q      <= ST_IDLE;
                  done_q    <= 1'b1;
                  fault_q   <= fin_code;
                  pa_q      <= {out_ppn, va_q[PGOFS_W-1:0]};
                  pte_q     <= mem_rsp_data_i;
                  pteaddr_q <= entry_addr;
                  lvlout_q  <= lvl_q;
                  globout_q <= glob_n;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o          = (st_q != ST_IDLE);
   assign done_o          = done_q;
   assign fault_o         = fault_q;
   assign pa_o            = pa_q;
   assign pte_o           = pte_q;
   assign pte_addr_o      = pteaddr_q;
   assign level_o         = lvlout_q;
   assign global_o        = globout_q;
   assign mem_req_valid_o = (st_q == ST_REQ);
   assign mem_req_addr_o  = entry_addr;

   // ---------------- assertions ----------------
   assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

   assert_first_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> mem_req_valid_o && (mem_req_addr_o[PTE_LOG-1:0] == '0 || root_i != root_i));

   assert_level_descends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) |-> lvl_q <= $past(lvl_q));

   assert_global_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) && $past(glob_q) |-> glob_q);

   assert_misalign_above0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) && fault_o == FLT_MISALIGN |-> level_o != '0);

   assert_offset_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) && fault_o == FLT_NONE |-> pa_o[PGOFS_W-1:0] == va_q[PGOFS_W-1:0]);

   assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   assert_result_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !start_i |=> done_o && $stable(pa_o) && $stable(fault_o) && $stable(pte_addr_o));

   assert_no_req_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_req_valid_o);

endmodule

// File: tb/test_ptw48_walker.sv
`timescale 1ns/1ps
module test_ptw48_walker;

   localparam logic [47:0] VA   = {9'h011, 9'h0A2, 9'h133, 9'h1C4, 12'h5A6};
   localparam logic [55:0] ROOT = 56'h0000_0000_100000;
   localparam logic [11:0] OFS  = 12'h5A6;

   typedef struct {
      string       tag;
      int          fault;
      logic [55:0] pa;
      int          level;
      bit          glob;
      logic [55:0] pteaddr;
      int          reads;
      logic [55:0] first_addr;
   } exp_t;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        start_i = 0;
   logic [47:0] va_i = '0;
   logic [1:0]  acc_i = '0;
   logic        user_i = 0, mxr_i = 0, sum_i = 0, global_i = 0;
   logic [55:0] root_i = '0;
   logic [1:0]  start_level_i = '0;
   logic        busy_o, done_o, global_o;
   logic [2:0]  fault_o;
   logic [55:0] pa_o, pte_addr_o, mem_req_addr_o;
   logic [63:0] pte_o;
   logic [1:0]  level_o;
   logic        mem_req_valid_o;
   logic        mem_req_ready_i = 1;
   logic        mem_rsp_valid_i = 0;
   logic [63:0] mem_rsp_data_i = '0;
   logic        mem_rsp_err_i = 0;

   always #2.5 clk = ~clk;

   ptw48_walker i_ptw48_walker (
      .clk, .rst_n, .start_i, .va_i, .acc_i, .user_i, .mxr_i, .sum_i,
      .root_i, .start_level_i, .global_i, .busy_o, .done_o, .fault_o,
      .pa_o, .pte_o, .pte_addr_o, .level_o, .global_o,
      .mem_req_valid_o, .mem_req_addr_o, .mem_req_ready_i,
      .mem_rsp_valid_i, .mem_rsp_data_i, .mem_rsp_err_i
   );

   int checks = 0, fails = 0, pushed = 0, handled = 0, rd_cnt = 0;
   logic [55:0] first_addr;
   logic [63:0] mem [logic [55:0]];
   bit          err_set [logic [55:0]];
   exp_t        sb [$];

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] mk_ptr(logic [43:0] ppn);
      return {10'b0, ppn, 10'h001};
   endfunction
   function automatic logic [63:0] mk_leaf(logic [43:0] ppn, logic [7:0] fl);
      return {10'b0, ppn, 2'b00, fl};
   endfunction
   function automatic logic [55:0] idx_ofs(int l);
      logic [8:0] ix = 9'(VA >> (12 + 9 * l));
      return {44'b0, ix, 3'b000};
   endfunction
   function automatic logic [43:0] tbl(int l);
      return 44'h200 + 44'(l);
   endfunction

   // memory responder: one cycle after acceptance, returns the word
   initial begin
      int phase = 0;
      logic [55:0] a;
      forever begin
         @(negedge clk);
         if (phase == 1) begin
            mem_rsp_valid_i = 1;
            mem_rsp_data_i  = mem.exists(a) ? mem[a] : 64'h0;
            mem_rsp_err_i   = err_set.exists(a);
            phase = 2;
         end else begin
            if (phase == 2) begin
               mem_rsp_valid_i = 0;
               mem_rsp_err_i   = 0;
               phase = 0;
            end
            if (mem_req_valid_o) begin
               a = mem_req_addr_o;
               if (rd_cnt == 0) first_addr = a;
               rd_cnt++;
               phase = 1;
            end
         end
      end
   end

   // monitor: compare each finished walk against the scoreboard
   initial begin
      bit prev = 0;
      forever begin
         @(negedge clk);
         if (done_o && !prev) begin
            exp_t e;
            if (sb.size() == 0) begin
               chk("R11", "unexpected done", 1, 0);
            end else begin
               e = sb.pop_front();
               chk(e.tag, "fault", 64'(fault_o), 64'(e.fault));
               chk("R2", "read count", 64'(rd_cnt), 64'(e.reads));
               chk("R1", "first read address", 64'(first_addr), 64'(e.first_addr));
               if (e.fault == 0) begin
                  chk(e.tag, "pa", 64'(pa_o), 64'(e.pa));
                  chk("R10", "level", 64'(level_o), 64'(e.level));
                  chk("R1", "leaf entry address", 64'(pte_addr_o), 64'(e.pteaddr));
                  chk("R6", "global", 64'(global_o), 64'(e.glob));
                  chk("R10", "leaf word", pte_o, mem[e.pteaddr]);
               end
            end
            handled++;
         end
         prev = done_o;
      end
   end

   task automatic do_case(string tag, int start_l, int leaf_l, logic [63:0] leaf_pte,
                          bit g_ptr, logic [1:0] acc, bit usr, bit mxr, bit sum, bit gin,
                          int efault, logic [55:0] epa, bit eglob, bit err_leaf, bit restart);
      logic [55:0] base = ROOT;
      logic [55:0] la;
      exp_t e;
      mem.delete();
      err_set.delete();
      for (int l = start_l; l > leaf_l; l--) begin
         mem[base + idx_ofs(l)] = mk_ptr(tbl(l - 1)) | ((g_ptr && l == start_l) ? 64'h20 : 64'h0);
         base = {tbl(l - 1), 12'h000};
      end
      la = base + idx_ofs(leaf_l);
      mem[la] = leaf_pte;
      if (err_leaf) err_set[la] = 1;
      e.tag = tag; e.fault = efault; e.pa = epa; e.level = leaf_l; e.glob = eglob;
      e.pteaddr = la; e.reads = start_l - leaf_l + 1; e.first_addr = ROOT + idx_ofs(start_l);
      sb.push_back(e);
      pushed++;
      @(negedge clk);
      rd_cnt = 0;
      va_i = VA; acc_i = acc; user_i = usr; mxr_i = mxr; sum_i = sum; global_i = gin;
      root_i = ROOT; start_level_i = 2'(start_l);
      start_i = 1;
      @(negedge clk);
      start_i = 0;
      if (restart) begin
         repeat (3) @(negedge clk);
         start_i = 1; va_i = VA ^ 48'h0FF_FFFF_F000; start_level_i = 2'd0;
         @(negedge clk);
         start_i = 0; va_i = VA;
      end
      wait (handled == pushed);
      @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R12", "busy in reset", 64'(busy_o), 0);
      chk("R12", "done in reset", 64'(done_o), 0);
      chk("R12", "req in reset", 64'(mem_req_valid_o), 0);
      rst_n = 1;
      @(negedge clk);

      // R10: four-level walk to a small page
      do_case("R10", 3, 0, mk_leaf(44'hABCDE, 8'h43), 0, 2'd0, 0, 0, 0, 0, 0, {44'hABCDE, OFS}, 0, 0, 0);
      // R9: aligned superpages at levels 1 and 2
      do_case("R9", 3, 1, mk_leaf(44'h34600, 8'h43), 0, 2'd0, 0, 0, 0, 0, 0, {44'h347C4, OFS}, 0, 0, 0);
      do_case("R9", 3, 2, mk_leaf(44'h80000, 8'h43), 0, 2'd0, 0, 0, 0, 0, 0, {44'hA67C4, OFS}, 0, 0, 0);
      // R8: one stray bit inside the mask
      do_case("R8", 3, 2, mk_leaf(44'h80001, 8'h43), 0, 2'd0, 0, 0, 0, 0, 4, '0, 0, 0, 0);
      do_case("R8", 3, 1, mk_leaf(44'h34700, 8'h43), 0, 2'd0, 0, 0, 0, 0, 4, '0, 0, 0, 0);
      // R4: invalid encodings
      do_case("R4", 3, 2, 64'h0, 0, 2'd0, 0, 0, 0, 0, 2, '0, 0, 0, 0);
      do_case("R4", 3, 1, mk_leaf(44'hABCDE, 8'h45), 0, 2'd0, 0, 0, 0, 0, 2, '0, 0, 0, 0);
      // R5: pointer at the bottom level
      do_case("R5", 3, 0, mk_ptr(44'h777), 0, 2'd0, 0, 0, 0, 0, 2, '0, 0, 0, 0);
      // R3: memory error on a read
      do_case("R3", 3, 1, mk_leaf(44'h34600, 8'h43), 0, 2'd0, 0, 0, 0, 0, 1, '0, 0, 1, 0);
      // R7: permission combinations
      do_case("R7", 3, 0, mk_leaf(44'hABCDE, 8'h53), 0, 2'd0, 0, 0, 0, 0, 3, '0, 0, 0, 0);
      do_case("R7", 3, 0, mk_leaf(44'hABCDE, 8'h53), 0, 2'd0, 0, 0, 1, 0, 0, {44'hABCDE, OFS}, 0, 0, 0);
      do_case("R7", 3, 0, mk_leaf(44'hABCDE, 8'h59), 0, 2'd2, 0, 0, 1, 0, 3, '0, 0, 0, 0);
      do_case("R7", 3, 0, mk_leaf(44'hABCDE, 8'h49), 0, 2'd0, 0, 0, 0, 0, 3, '0, 0, 0, 0);
      do_case("R7", 3, 0, mk_leaf(44'hABCDE, 8'h49), 0, 2'd0, 0, 1, 0, 0, 0, {44'hABCDE, OFS}, 0, 0, 0);
      do_case("R7", 3, 0, mk_leaf(44'hABCDE, 8'h43), 0, 2'd1, 0, 0, 0, 0, 3, '0, 0, 0, 0);
      do_case("R7", 3, 0, mk_leaf(44'hABCDE, 8'h43), 0, 2'd0, 1, 0, 0, 0, 3, '0, 0, 0, 0);
      do_case("R7", 3, 0, mk_leaf(44'hABCDE, 8'hD7), 0, 2'd1, 1, 0, 0, 0, 0, {44'hABCDE, OFS}, 0, 0, 0);
      do_case("R7", 3, 0, mk_leaf(44'hABCDE, 8'h49), 0, 2'd2, 0, 0, 0, 0, 0, {44'hABCDE, OFS}, 0, 0, 0);
      // R6: global from the top pointer, from the input, from the leaf
      do_case("R6", 3, 0, mk_leaf(44'hABCDE, 8'h43), 1, 2'd0, 0, 0, 0, 0, 0, {44'hABCDE, OFS}, 1, 0, 0);
      do_case("R6", 3, 0, mk_leaf(44'hABCDE, 8'h43), 0, 2'd0, 0, 0, 0, 1, 0, {44'hABCDE, OFS}, 1, 0, 0);
      do_case("R6", 3, 1, mk_leaf(44'h34600, 8'h63), 0, 2'd0, 0, 0, 0, 0, 0, {44'h347C4, OFS}, 1, 0, 0);
      // R1: shorter walks from lower start levels
      do_case("R1", 1, 0, mk_leaf(44'h12345, 8'h43), 0, 2'd0, 0, 0, 0, 0, 0, {44'h12345, OFS}, 0, 0, 0);
      do_case("R1", 0, 0, mk_leaf(44'h54321, 8'h43), 0, 2'd0, 0, 0, 0, 0, 0, {44'h54321, OFS}, 0, 0, 0);
      // R11: start during a walk is ignored
      do_case("R11", 3, 0, mk_leaf(44'hABCDE, 8'h43), 0, 2'd0, 0, 0, 0, 0, 0, {44'hABCDE, OFS}, 0, 0, 1);
      // R11: result held while idle
      repeat (5) @(negedge clk);
      chk("R11", "held done", 64'(done_o), 1);
      chk("R11", "held pa", 64'(pa_o), 64'({44'hABCDE, OFS}));

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule